// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Unit

This unit keeps the event flags of one endpoint in a full-speed USB device controller. The protocol engine sends one-cycle event pulses: packet received, SETUP received, NAK sent, overflow, underflow, CRC error, STALL sent, short packet at DMA end, and bank full. It also supplies the endpoint's current kind (control, isochronous, bulk, interrupt) and direction. The unit qualifies each pulse against the endpoint kind, direction and two DMA configuration bits, and turns the qualified pulses into sticky flags. It combines the flags with an enable mask into one endpoint interrupt line.

Software uses a small synchronous register port with four addresses: a status view, a write-one-to-clear register, a write-one-to-set register and an enable mask. The write-one-to-set register only affects the stall request. The stall request is driven out to the protocol engine, and a STALL-sent report is honoured only while it is set. One internal flag is shared between two meanings. On control endpoints it means "SETUP received", on isochronous endpoints it means "underflow", and on bulk and interrupt endpoints it is hidden. It is visible at two status positions. On control endpoints, clearing the received-OUT flag or the shared flag emits a one-cycle bank-release pulse.

The register port has no handshake. A write takes effect at the clock edge where `reg_wr_i` is high. Read data is a combinational function of `reg_addr_i` and the current state. No data stream passes through the block, so it has no valid/ready interface.

Top module: `ep_irq_status`

## Requirements
- R1: Status bit map (address 0): bit0 received-OUT, bit1 shared SETUP/underflow, bit2 NAK-on-OUT, bit3 NAK-on-IN, bit4 overflow, bit5 CRC error, bit6 stalled, bit7 short packet, bit8 shared SETUP/underflow (alias of bit1), bit9 stall request; the rest read zero. NAK-on-IN, NAK-on-OUT and overflow events set their flag on any endpoint kind, one clock edge after the pulse. Each flag stays set until a one is written to the same bit of the clear register (address 1).
- R2: `ep_irq_o` is high exactly when some status bit in 8..0 is one and the same bit of the enable register (address 3, bits 8..0, readable) is one.
- R3: Endpoint kind encoding is 0 control, 1 isochronous, 2 bulk, 3 interrupt. The shared flag is set by the SETUP event on control endpoints and by the underflow event on isochronous endpoints. It reads as one at both bit1 and bit8, and writing one to either clear bit clears it. On bulk and interrupt endpoints it is never set, and it reads and interrupts as zero.
- R4: Writing one to bit9 of the set register (address 2) sets the stall request (status bit9, pin `stall_rq_o`). Writing one to bit9 of the clear register resets it. The stalled flag is set by a STALL-sent event only while the stall request is one.
- R5: The short-packet flag is set only on a non-control IN endpoint (`dir_in_i`=1), and only when `dmaend_en_i` and `auto_sw_i` are both one.
- R6: The CRC-error flag is set only on an isochronous OUT endpoint (`dir_in_i`=0).
- R7: Received-OUT is set by `ev_rx_out_i` on control endpoints. On non-control OUT endpoints it is set by `ev_bank_full_i`, at the same clock edge at which the bank-full indication is taken.
- R8: On a control endpoint, a clear write with bit0, bit1 or bit8 at one makes `bank_release_o` high for exactly the one cycle after that edge. On other kinds no pulse is made.
- R9: A set event and a clear write that reach the same flag at the same edge leave the flag set.
- R10: Zero bits written to the clear or set register change nothing. Bits 8..0 of the set register have no effect. Reading address 1 or 2 returns zero.
- R11: After reset all flags, the stall request, the enable mask, `ep_irq_o` and `bank_release_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_kind_i | input | 2 | Endpoint kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| dir_in_i | input | 1 | 1 for an IN endpoint, 0 for OUT |
| dmaend_en_i | input | 1 | End-of-DMA-buffer short packet enable |
| auto_sw_i | input | 1 | Automatic bank switch enable |
| ev_rx_out_i | input | 1 | Pulse: OUT packet received (control endpoints) |
| ev_setup_i | input | 1 | Pulse: valid SETUP packet in bank |
| ev_underflow_i | input | 1 | Pulse: isochronous underflow |
| ev_bank_full_i | input | 1 | Pulse: bank became full (non-control OUT) |
| ev_nak_in_i | input | 1 | Pulse: NAK sent to an IN token |
| ev_nak_out_i | input | 1 | Pulse: NAK sent to an OUT token |
| ev_overflow_i | input | 1 | Pulse: packet larger than bank |
| ev_crc_err_i | input | 1 | Pulse: CRC error on received packet |
| ev_stall_sent_i | input | 1 | Pulse: STALL handshake sent |
| ev_short_i | input | 1 | Pulse: short packet sent at end of DMA |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 clear, 2 set, 3 enable |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| stall_rq_o | output | 1 | Stall request to protocol engine |
| bank_release_o | output | 1 | One-cycle bank release (control endpoints) |
| ep_irq_o | output | 1 | Combined endpoint interrupt |

## Verification
The assertions assume that each event input is a single-cycle pulse. They also assume that the endpoint kind and direction describe the endpoint at the edge where a pulse is taken. The STALL-sent and short-packet checks depend on those inputs being meaningful one edge earlier. The interrupt-rise check only allows three causes: a qualified event, an enable write or a change of endpoint kind. The bench changes kind, direction and DMA bits only at falling edges, and never in the same cycle as an event pulse. It raises each event for exactly one cycle and holds kind and direction constant from the pulse until the status read.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_kind_e;

  localparam int NFLAG = 8;   // internal sticky flags
  localparam int NSTAT = 10;  // visible status bits
  localparam int NIRQ  = 9;   // status bits that can interrupt

  // internal flag indices (also status positions 0..7)
  localparam int F_RXOUT  = 0;
  localparam int F_SHARED = 1;
  localparam int F_NAKOUT = 2;
  localparam int F_NAKIN  = 3;
  localparam int F_OVF    = 4;
  localparam int F_CRC    = 5;
  localparam int F_STALL  = 6;
  localparam int F_SHORT  = 7;
  // status-only positions
  localparam int S_ALIAS  = 8;
  localparam int S_STALLRQ = 9;

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CLR  = 2'd1;
  localparam logic [1:0] A_SET  = 2'd2;
  localparam logic [1:0] A_EN   = 2'd3;
endpackage

// File: rtl/ep_event_qual.sv
module ep_event_qual
  import ep_irq_pkg::*;
(
  input  ep_kind_e         kind_i,
  input  logic             dir_in_i,
  input  logic             dmaend_en_i,
  input  logic             auto_sw_i,
  input  logic             stall_rq_i,
  input  logic             ev_rx_out_i,
  input  logic             ev_setup_i,
  input  logic             ev_underflow_i,
  input  logic             ev_bank_full_i,
  input  logic             ev_nak_in_i,
  input  logic             ev_nak_out_i,
  input  logic             ev_overflow_i,
  input  logic             ev_crc_err_i,
  input  logic             ev_stall_sent_i,
  input  logic             ev_short_i,
  output logic [NFLAG-1:0] set_o
);
  logic is_ctrl, is_iso;
  assign is_ctrl = (kind_i == EP_CTRL);
  assign is_iso  = (kind_i == EP_ISO);

  always_comb begin
    set_o           = '0;
    // R7: received-OUT source depends on endpoint kind
    set_o[F_RXOUT]  = is_ctrl ? ev_rx_out_i : (!dir_in_i && ev_bank_full_i);
    // R3: shared position
    set_o[F_SHARED] = (is_ctrl && ev_setup_i) || (is_iso && ev_underflow_i);
    set_o[F_NAKOUT] = ev_nak_out_i;
    set_o[F_NAKIN]  = ev_nak_in_i;
    set_o[F_OVF]    = ev_overflow_i;
    // R6
    set_o[F_CRC]    = is_iso && !dir_in_i && ev_crc_err_i;
    // R4
    set_o[F_STALL]  = stall_rq_i && ev_stall_sent_i;
    // R5
    set_o[F_SHORT]  = !is_ctrl && dir_in_i && dmaend_en_i && auto_sw_i && ev_short_i;
  end
endmodule

// File: rtl/ep_flag_bank.sv
module ep_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;   // set wins over clear
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & ~clr_i)) |=> ((flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i)));
endmodule

// File: rtl/ep_reg_port.sv
module ep_reg_port
  import ep_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSTAT-1:0]  status_i,
  output logic [NFLAG-1:0]  clr_o,
  output logic              rq_set_o,
  output logic              rq_clr_o,
  output logic [NIRQ-1:0]   en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_clr, wr_set, wr_en;
  logic [NIRQ-1:0] en_q;

  assign wr_clr = wr_i && (addr_i == ADDR_W'(A_CLR));
  assign wr_set = wr_i && (addr_i == ADDR_W'(A_SET));
  assign wr_en  = wr_i && (addr_i == ADDR_W'(A_EN));

  always_comb begin
    clr_o = '0;
    if (wr_clr) begin
      clr_o           = wdata_i[NFLAG-1:0];
      clr_o[F_SHARED] = wdata_i[F_SHARED] | wdata_i[S_ALIAS];
    end
  end

  assign rq_set_o = wr_set && wdata_i[S_STALLRQ];
  assign rq_clr_o = wr_clr && wdata_i[S_STALLRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wdata_i[NIRQ-1:0];
  end
  assign en_o = en_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_STAT): rdata_o[NSTAT-1:0] = status_i;
      ADDR_W'(A_EN):   rdata_o[NIRQ-1:0]  = en_q;
      default:         rdata_o = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^wdata_i[DATA_W-1:NSTAT];

  // R10
  wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_i == ADDR_W'(A_CLR)) || (addr_i == ADDR_W'(A_SET))) |-> (rdata_o == '0));
endmodule

// File: rtl/ep_irq_status.sv
module ep_irq_status
  import ep_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ep_kind_i,
  input  logic              dir_in_i,
  input  logic              dmaend_en_i,
  input  logic              auto_sw_i,
  input  logic              ev_rx_out_i,
  input  logic              ev_setup_i,
  input  logic              ev_underflow_i,
  input  logic              ev_bank_full_i,
  input  logic              ev_nak_in_i,
  input  logic              ev_nak_out_i,
  input  logic              ev_overflow_i,
  input  logic              ev_crc_err_i,
  input  logic              ev_stall_sent_i,
  input  logic              ev_short_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              stall_rq_o,
  output logic              bank_release_o,
  output logic              ep_irq_o
);
  ep_kind_e kind;
  assign kind = ep_kind_e'(ep_kind_i);

  logic [NFLAG-1:0] set_vec, clr_vec, flags;
  logic [NIRQ-1:0]  en_vec;
  logic [NSTAT-1:0] status_vis;
  logic rq_set, rq_clr, stall_rq_q, rel_q, shared_vis;

  ep_event_qual u_qual (
    .kind_i          (kind),
    .dir_in_i        (dir_in_i),
    .dmaend_en_i     (dmaend_en_i),
    .auto_sw_i       (auto_sw_i),
    .stall_rq_i      (stall_rq_q),
    .ev_rx_out_i     (ev_rx_out_i),
    .ev_setup_i      (ev_setup_i),
    .ev_underflow_i  (ev_underflow_i),
    .ev_bank_full_i  (ev_bank_full_i),
    .ev_nak_in_i     (ev_nak_in_i),
    .ev_nak_out_i    (ev_nak_out_i),
    .ev_overflow_i   (ev_overflow_i),
    .ev_crc_err_i    (ev_crc_err_i),
    .ev_stall_sent_i (ev_stall_sent_i),
    .ev_short_i      (ev_short_i),
    .set_o           (set_vec)
  );

  ep_flag_bank #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flags)
  );

  ep_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_vis),
    .clr_o    (clr_vec),
    .rq_set_o (rq_set),
    .rq_clr_o (rq_clr),
    .en_o     (en_vec),
    .rdata_o  (reg_rdata_o)
  );

  // stall request: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stall_rq_q <= 1'b0;
    else if (rq_set) stall_rq_q <= 1'b1;
    else if (rq_clr) stall_rq_q <= 1'b0;
  end
  assign stall_rq_o = stall_rq_q;

  // shared flag is hidden on bulk and interrupt endpoints
  assign shared_vis = flags[F_SHARED] && ((kind == EP_CTRL) || (kind == EP_ISO));

  always_comb begin
    status_vis            = '0;
    status_vis[NFLAG-1:0] = flags;
    status_vis[F_SHARED]  = shared_vis;
    status_vis[S_ALIAS]   = shared_vis;
    status_vis[S_STALLRQ] = stall_rq_q;
  end

  assign ep_irq_o = |(status_vis[NIRQ-1:0] & en_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= (kind == EP_CTRL) && (clr_vec[F_RXOUT] || clr_vec[F_SHARED]);
  end
  assign bank_release_o = rel_q;

  // R2
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ep_irq_o) |-> ($past(|set_vec) || $past(reg_wr_i && reg_addr_i == ADDR_W'(A_EN))
                         || (ep_kind_i != $past(ep_kind_i))));

  // R3
  shared_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ep_kind_i[1] == 1'b1) && (reg_addr_i == ADDR_W'(A_STAT)))
      |-> (!reg_rdata_o[F_SHARED] && !reg_rdata_o[S_ALIAS]));

  // R4
  stall_needs_rq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_STALL]) |-> $past(stall_rq_q));

  // R5
  short_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_SHORT]) |-> $past(dmaend_en_i && auto_sw_i && dir_in_i && ep_kind_i != 2'd0));

  // R6
  crc_iso_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_CRC]) |-> $past(ep_kind_i == 2'd1 && !dir_in_i));

  // R8
  release_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_release_o |-> ($past(ep_kind_i) == 2'd0));
endmodule

// File: tb/test_ep_irq_status.sv
module test_ep_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  kind;
  logic        dir_in, dmaend, autosw;
  logic [9:0]  ev;   // 0 rx_out,1 setup,2 nak_out,3 nak_in,4 ovf,5 crc,6 stall_sent,7 short,8 underflow,9 bank_full
  logic        wr;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic        stall_rq, bank_rel, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ep_irq_status i_ep_irq_status (
    .clk(clk), .rst_n(rst_n), .ep_kind_i(kind), .dir_in_i(dir_in),
    .dmaend_en_i(dmaend), .auto_sw_i(autosw),
    .ev_rx_out_i(ev[0]), .ev_setup_i(ev[1]), .ev_underflow_i(ev[8]),
    .ev_bank_full_i(ev[9]), .ev_nak_in_i(ev[3]), .ev_nak_out_i(ev[2]),
    .ev_overflow_i(ev[4]), .ev_crc_err_i(ev[5]), .ev_stall_sent_i(ev[6]),
    .ev_short_i(ev[7]), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .stall_rq_o(stall_rq), .bank_release_o(bank_rel),
    .ep_irq_o(irq)
  );

  // {kind[2], dir_in, dmaend, autosw, events[10], expected status[10]}
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 10'h003, 10'h103},
    {2'd1, 1'b0, 1'b0, 1'b0, 10'h320, 10'h123},
    {2'd2, 1'b0, 1'b0, 1'b0, 10'h303, 10'h001},
    {2'd3, 1'b1, 1'b1, 1'b1, 10'h088, 10'h088},
    {2'd2, 1'b1, 1'b1, 1'b0, 10'h080, 10'h000},
    {2'd0, 1'b1, 1'b1, 1'b1, 10'h080, 10'h000},
    {2'd1, 1'b1, 1'b0, 1'b0, 10'h034, 10'h014},
    {2'd2, 1'b0, 1'b0, 1'b0, 10'h040, 10'h000},
    {2'd0, 1'b0, 1'b0, 1'b0, 10'h200, 10'h000},
    {2'd1, 1'b0, 1'b1, 1'b1, 10'h080, 10'h000},
    {2'd3, 1'b0, 1'b0, 1'b0, 10'h214, 10'h015}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [9:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    kind = 2'd0; dir_in = 0; dmaend = 0; autosw = 0; ev = '0;
    wr = 0; addr = 0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    reg_read(2'd0, d); check("R11 status after reset", d, 16'h0000);
    reg_read(2'd3, d); check("R11 enable after reset", d, 16'h0000);
    check("R11 irq/release after reset", {14'd0, irq, bank_rel}, 16'h0000);

    // table walk: R1 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      reg_write(2'd1, 16'h03FF);
      @(negedge clk);
      kind = VEC[i][24:23]; dir_in = VEC[i][22]; dmaend = VEC[i][21]; autosw = VEC[i][20];
      pulse(VEC[i][19:10]);
      reg_read(2'd0, d);
      check($sformatf("R1/R3/R5/R6/R7 vector %0d", i), d, {6'd0, VEC[i][9:0]});
    end

    // R1 sticky, R10 zero writes
    reg_write(2'd1, 16'h03FF);
    kind = 2'd2; dir_in = 0;
    pulse(10'h01C);
    reg_write(2'd1, 16'h0000);
    reg_write(2'd2, 16'h01FF);
    reg_read(2'd0, d); check("R10 zero clear / low set bits ignored", d, 16'h001C);
    reg_read(2'd1, d); check("R10 clear reads zero", d, 16'h0000);
    reg_read(2'd2, d); check("R10 set reads zero", d, 16'h0000);
    reg_write(2'd1, 16'h0004);
    reg_read(2'd0, d); check("R1 single bit clear", d, 16'h0018);

    // R9 set wins
    @(negedge clk); ev = 10'h008; wr = 1; addr = 2'd1; wdata = 16'h0008;
    @(negedge clk); ev = '0; wr = 0; wdata = '0;
    reg_read(2'd0, d); check("R9 set beats clear", d, 16'h0018);
    reg_write(2'd1, 16'h03FF);

    // R2 interrupt mask
    pulse(10'h010);
    reg_write(2'd3, 16'h0008);
    check("R2 masked flag no irq", {15'd0, irq}, 16'h0000);
    reg_write(2'd3, 16'h0010);
    check("R2 enabled flag irq", {15'd0, irq}, 16'h0001);
    reg_read(2'd3, d); check("R2 enable readback", d, 16'h0010);
    reg_write(2'd1, 16'h0010);
    check("R2 cleared flag irq low", {15'd0, irq}, 16'h0000);

    // R4 stall request
    pulse(10'h040);
    reg_read(2'd0, d); check("R4 stall without request", d, 16'h0000);
    reg_write(2'd2, 16'h0200);
    check("R4 stall request pin", {15'd0, stall_rq}, 16'h0001);
    pulse(10'h040);
    reg_read(2'd0, d); check("R4 stalled after request", d, 16'h0240);
    reg_write(2'd1, 16'h0200);
    reg_read(2'd0, d); check("R4 request cleared", d, 16'h0040);
    reg_write(2'd1, 16'h03FF);

    // R3 hidden on bulk, R8 release
    kind = 2'd0;
    pulse(10'h002);
    reg_write(2'd3, 16'h0100);
    check("R3 alias irq on control", {15'd0, irq}, 16'h0001);
    @(negedge clk); kind = 2'd2; #1;
    reg_read(2'd0, d); check("R3 shared hidden on bulk", d, 16'h0000);
    check("R3 hidden irq", {15'd0, irq}, 16'h0000);
    @(negedge clk); kind = 2'd0;
    reg_write(2'd1, 16'h0100);
    check("R8 release after control clear", {15'd0, bank_rel}, 16'h0001);
    reg_read(2'd0, d); check("R3 alias clear clears both", d, 16'h0000);
    @(negedge clk);
    check("R8 release one cycle", {15'd0, bank_rel}, 16'h0000);
    kind = 2'd1;
    pulse(10'h100);
    reg_write(2'd1, 16'h0002);
    check("R8 no release on iso", {15'd0, bank_rel}, 16'h0000);
    reg_read(2'd0, d); check("R3 iso underflow cleared", d, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule